// File: doc/BRIEF.md
# Key-Unlocked Register Write Guard

This block guards writes to a small configuration register block. It uses two separate protection schemes.

The first scheme covers a bank of protected registers. Software opens the bank by writing a fixed 32-bit key to an unlock register. The bank closes again in either of two cases: a wrong value is written to that unlock register, or the bank sees no write for a fixed run of idle cycles.

The second scheme covers a single keyed configuration register. That register takes a write only when the top byte of the write data holds the correct key byte. When software has finished configuring it, software writes it again with a wrong key.

Access is through a single-cycle synchronous write port and a combinational read port. The block also drives a lock-status output and exposes the register contents directly as outputs.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset the bank is locked (`unlocked_o` = 0), every bank register reads 0, and the keyed register reads 0.
- R2: A write of 0xC5AF6927 to the unlock address (`UNLOCK_ADDR`, default 0x00) makes `unlocked_o` 1 from the next cycle. The idle count restarts.
- R3: A write of any other value to the unlock address, including the lock code 0, makes `unlocked_o` 0 from the next cycle.
- R4: A write to a bank register while the bank is locked is dropped, and every bank register keeps its value.
- R5: A write to bank register i (address `MUT_BASE`+i, default base 0x10, four registers) while unlocked stores the full 32-bit word from the next cycle.
- R6: Once unlocked, if `IDLE_CYCLES` (default 32) consecutive clock edges pass with no write to the bank, `unlocked_o` falls at the last of those edges.
- R7: An accepted write to any bank register restarts the idle count. Writes to the keyed register or to unmapped addresses do not restart it.
- R8: A write to the keyed register (`KEYED_ADDR`, default 0x04) updates its 24 payload bits [23:0] only when write data bits [31:24] equal 0x5A. Otherwise it keeps its value. The bank lock has no effect on this register.
- R9: A read of the keyed register returns 0 in bits [31:24] and the stored payload in bits [23:0].
- R10: A read of the unlock address returns `unlocked_o` in bit 0 and zeros above it. A read of a bank register returns its contents. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | AW | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| unlocked_o | output | 1 | 1 while the protected bank is open |
| mut_q_o | output | 32*N_MUT | Protected bank contents, register i at [32i+31:32i] |
| keyed_q_o | output | 24 | Keyed register payload |

## Verification
The bench builds the block with the default parameters: four bank registers, a 32-cycle idle window and an 8-bit address. With these values, every bank register can be written and read back in a short run. The full idle window can be walked cycle by cycle, so the bench checks both that the bank stays open after 31 idle cycles and that it locks exactly on the 32nd. It also checks that the window restarts after a bank write, and that keyed-register writes and unmapped writes do not restart it.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 8;
  localparam int CFG_W  = WORD_W - KEY_W;

  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hC5AF_6927;
  localparam logic [KEY_W-1:0]  CFG_KEY    = 8'h5A;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_UNLOCK = 2'd1,
    SEL_KEYED  = 2'd2,
    SEL_MUT    = 2'd3
  } sel_e;
endpackage

// File: rtl/wg_decode.sv
module wg_decode import wg_pkg::*; #(
  parameter int AW    = 8,
  parameter int N_MUT = 4,
  parameter int IDXW  = 2,
  parameter logic [AW-1:0] UNLOCK_ADDR = 'h00,
  parameter logic [AW-1:0] KEYED_ADDR  = 'h04,
  parameter logic [AW-1:0] MUT_BASE    = 'h10
) (
  input  logic [AW-1:0]   addr_i,
  output sel_e            sel_o,
  output logic [IDXW-1:0] idx_o
);
  logic [AW:0] off;
  logic        in_mut;

  assign off    = {1'b0, addr_i} - {1'b0, MUT_BASE};
  assign in_mut = ({1'b0, addr_i} >= {1'b0, MUT_BASE}) && (off < (AW+1)'(N_MUT));
  assign idx_o  = off[IDXW-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == UNLOCK_ADDR)     sel_o = SEL_UNLOCK;
    else if (addr_i == KEYED_ADDR) sel_o = SEL_KEYED;
    else if (in_mut)               sel_o = SEL_MUT;
  end
endmodule

// File: rtl/wg_lock_ctrl.sv
module wg_lock_ctrl #(
  parameter int IDLE_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_wr_i,
  input  logic key_ok_i,
  input  logic mut_wr_i,
  output logic unlocked_o
);
  localparam int CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] idle_q;
  logic          unl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q  <= 1'b0;
      idle_q <= '0;
    end else if (unlock_wr_i) begin
      unl_q  <= key_ok_i;
      idle_q <= '0;
    end else if (unl_q && mut_wr_i) begin
      idle_q <= '0;
    end else if (unl_q) begin
      if (idle_q == LAST) begin
        unl_q  <= 1'b0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign unlocked_o = unl_q;
endmodule

// File: rtl/wg_mut_bank.sv
module wg_mut_bank import wg_pkg::*; #(
  parameter int N_MUT = 4,
  parameter int IDXW  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDXW-1:0]         idx_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [N_MUT*WORD_W-1:0] q_o
);
  for (genvar i = 0; i < N_MUT; i++) begin : g_reg
    logic [WORD_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r_q <= '0;
      else if (wr_i && idx_i == IDXW'(i))   r_q <= wdata_i;
    end
    assign q_o[i*WORD_W +: WORD_W] = r_q;
  end
endmodule

// File: rtl/wg_keyed_reg.sv
module wg_keyed_reg import wg_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  q_o
);
  logic key_ok;
  assign key_ok = (wdata_i[WORD_W-1 -: KEY_W] == CFG_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= '0;
    else if (wr_i && key_ok)  q_o <= wdata_i[CFG_W-1:0];
  end
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard import wg_pkg::*; #(
  parameter int AW          = 8,
  parameter int N_MUT       = 4,
  parameter int IDLE_CYCLES = 32,
  parameter logic [AW-1:0] UNLOCK_ADDR = 'h00,
  parameter logic [AW-1:0] KEYED_ADDR  = 'h04,
  parameter logic [AW-1:0] MUT_BASE    = 'h10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    unlocked_o,
  output logic [N_MUT*32-1:0]     mut_q_o,
  output logic [23:0]             keyed_q_o
);
  localparam int IDXW = (N_MUT > 1) ? $clog2(N_MUT) : 1;

  sel_e            sel;
  logic [IDXW-1:0] idx;
  logic            unlock_wr, key_ok, mut_wr, keyed_wr;

  wg_decode #(
    .AW(AW), .N_MUT(N_MUT), .IDXW(IDXW),
    .UNLOCK_ADDR(UNLOCK_ADDR), .KEYED_ADDR(KEYED_ADDR), .MUT_BASE(MUT_BASE)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .idx_o(idx)
  );

  assign unlock_wr = wr_en_i && (sel == SEL_UNLOCK);
  assign key_ok    = (wdata_i == UNLOCK_KEY);
  assign mut_wr    = wr_en_i && (sel == SEL_MUT);
  assign keyed_wr  = wr_en_i && (sel == SEL_KEYED);

  wg_lock_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .unlock_wr_i(unlock_wr), .key_ok_i(key_ok), .mut_wr_i(mut_wr),
    .unlocked_o(unlocked_o)
  );

  wg_mut_bank #(.N_MUT(N_MUT), .IDXW(IDXW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(mut_wr && unlocked_o), .idx_i(idx), .wdata_i(wdata_i),
    .q_o(mut_q_o)
  );

  wg_keyed_reg u_keyed (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(keyed_wr), .wdata_i(wdata_i), .q_o(keyed_q_o)
  );

  always_comb begin
    unique case (sel)
      SEL_UNLOCK: rdata_o = {31'd0, unlocked_o};
      SEL_KEYED:  rdata_o = {{KEY_W{1'b0}}, keyed_q_o};
      SEL_MUT:    rdata_o = mut_q_o[WORD_W*idx +: WORD_W];
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wg_guard_checker.sv
module wg_guard_checker #(
  parameter int AW          = 8,
  parameter int N_MUT       = 4,
  parameter int IDLE_CYCLES = 32,
  parameter logic [AW-1:0] UNLOCK_ADDR = 'h00,
  parameter logic [AW-1:0] KEYED_ADDR  = 'h04,
  parameter logic [AW-1:0] MUT_BASE    = 'h10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [AW-1:0]       addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic                unlocked_o,
  input logic [N_MUT*32-1:0] mut_q_o,
  input logic [23:0]         keyed_q_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 2) + 1;

  logic          key_wr, bad_wr, bank_hit, keyed_wr;
  logic [CW-1:0] idle_cnt;

  assign key_wr   = wr_en_i && addr_i == UNLOCK_ADDR && wdata_i == 32'hC5AF_6927;
  assign bad_wr   = wr_en_i && addr_i == UNLOCK_ADDR && wdata_i != 32'hC5AF_6927;
  assign bank_hit = ({1'b0, addr_i} >= {1'b0, MUT_BASE}) &&
                    ({1'b0, addr_i} <  {1'b0, MUT_BASE} + (AW+1)'(N_MUT));
  assign keyed_wr = wr_en_i && addr_i == KEYED_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idle_cnt <= '0;
    else if (key_wr)                          idle_cnt <= '0;
    else if (wr_en_i && bank_hit && unlocked_o) idle_cnt <= '0;
    else if (unlocked_o)                      idle_cnt <= idle_cnt + 1'b1;
    else                                      idle_cnt <= '0;
  end

  assert_key_unlocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> unlocked_o);

  assert_bad_key_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> !unlocked_o);

  assert_locked_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && wr_en_i && bank_hit) |=> $stable(mut_q_o));

  assert_window_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |-> (idle_cnt < CW'(IDLE_CYCLES)));

  assert_idle_relock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && idle_cnt == CW'(IDLE_CYCLES - 1) && !key_wr && !(wr_en_i && bank_hit))
    |=> !unlocked_o);

  assert_keyed_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!keyed_wr || wdata_i[31:24] != 8'h5A) |=> $stable(keyed_q_o));

  assert_keyed_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyed_wr && wdata_i[31:24] == 8'h5A) |=> keyed_q_o == $past(wdata_i[23:0]));

  assert_keyed_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == KEYED_ADDR) |-> (rdata_o == {8'h00, keyed_q_o}));

  for (genvar i = 0; i < N_MUT; i++) begin : g_chk
    assert_bank_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unlocked_o && wr_en_i && addr_i == MUT_BASE + AW'(i))
      |=> mut_q_o[i*32 +: 32] == $past(wdata_i));
  end
endmodule

bind cfg_write_guard wg_guard_checker #(
  .AW(AW), .N_MUT(N_MUT), .IDLE_CYCLES(IDLE_CYCLES),
  .UNLOCK_ADDR(UNLOCK_ADDR), .KEYED_ADDR(KEYED_ADDR), .MUT_BASE(MUT_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .unlocked_o(unlocked_o),
  .mut_q_o(mut_q_o), .keyed_q_o(keyed_q_o)
);

// File: tb/cfg_write_guard_test.sv
module cfg_write_guard_test;
  localparam int AW = 8;
  localparam int N_MUT = 4;
  localparam int IDLE = 32;
  localparam logic [7:0] A_UNL = 8'h00;
  localparam logic [7:0] A_KEY = 8'h04;
  localparam logic [7:0] A_MUT = 8'h10;
  localparam logic [31:0] KEY = 32'hC5AF_6927;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic unlocked_o;
  logic [N_MUT*32-1:0] mut_q_o;
  logic [23:0] keyed_q_o;

  always #4 clk_i = ~clk_i;

  cfg_write_guard uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .unlocked_o(unlocked_o),
    .mut_q_o(mut_q_o), .keyed_q_o(keyed_q_o)
  );

  typedef struct {
    int          kind;  // 0 lock state, 1 bank reg, 2 keyed reg, 3 read data
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // requirement model
  logic        m_unl = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_mut [N_MUT];
  logic [23:0] m_keyed = '0;

  task automatic push(int kind, int idx, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, string tag);
    bit hit;
    wr_en_i = we; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    hit = (a >= A_MUT) && (a < A_MUT + N_MUT);
    if (we && a == A_KEY && d[31:24] == 8'h5A) m_keyed = d[23:0];
    if (we && a == A_UNL) begin
      m_unl = (d == KEY); m_cnt = 0;
    end else if (we && hit && m_unl) begin
      m_mut[a - A_MUT] = d; m_cnt = 0;
    end else if (m_unl) begin
      if (m_cnt == IDLE - 1) begin m_unl = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    push(0, 0, {31'd0, m_unl}, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'hF0, '0, tag);
  endtask

  task automatic exp_mut(int i, string tag);
    push(1, i, m_mut[i], tag);
  endtask

  task automatic exp_keyed(string tag);
    push(2, 0, {8'h00, m_keyed}, tag);
  endtask

  task automatic exp_rd(logic [7:0] a, logic [31:0] e, string tag);
    addr_i = a;
    push(3, 0, e, tag);
    step(1'b0, a, '0, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.kind)
          0: got = {31'd0, unlocked_o};
          1: got = mut_q_o[it.idx*32 +: 32];
          2: got = {8'h00, keyed_q_o};
          default: got = rdata_o;
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.tag, it.kind, it.idx, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_MUT; i++) m_mut[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    push(0, 0, 32'd0, "R1");
    for (int i = 0; i < N_MUT; i++) exp_mut(i, "R1");
    exp_keyed("R1");
    exp_rd(A_UNL, 32'd0, "R1 R10");

    // R4 locked write dropped
    step(1'b1, A_MUT + 8'd1, 32'h1111_1111, "R4");
    exp_mut(1, "R4");

    // R2 unlock, R5 bank writes, R10 read back
    step(1'b1, A_UNL, KEY, "R2");
    exp_rd(A_UNL, 32'd1, "R10");
    for (int i = 0; i < N_MUT; i++)
      step(1'b1, A_MUT + 8'(i), 32'hA000_0000 + 32'(i * 32'h0101_0101), "R5");
    for (int i = 0; i < N_MUT; i++) exp_mut(i, "R5");
    exp_rd(A_MUT + 8'd2, m_mut[2], "R10");
    exp_rd(A_MUT + 8'd3, m_mut[3], "R10");
    exp_rd(8'hC0, 32'd0, "R10");

    // R3 wrong key locks, then R4 drop
    step(1'b1, A_UNL, 32'h1234_5678, "R3");
    step(1'b1, A_MUT + 8'd2, 32'hDEAD_BEEF, "R4");
    exp_mut(2, "R4");

    // R3 lock code zero
    step(1'b1, A_UNL, KEY, "R2");
    step(1'b1, A_UNL, 32'd0, "R3");

    // R6 idle window
    step(1'b1, A_UNL, KEY, "R2");
    idle(IDLE - 1, "R6");
    push(0, 0, 32'd1, "R6 still open after 31 idle");
    idle(1, "R6");
    push(0, 0, 32'd0, "R6 locked at 32nd idle");

    // R7 bank write restarts window
    step(1'b1, A_UNL, KEY, "R2");
    idle(20, "R7");
    step(1'b1, A_MUT, 32'h5555_AAAA, "R7");
    exp_mut(0, "R7");
    idle(IDLE - 1, "R7");
    push(0, 0, 32'd1, "R7 restarted window open");
    idle(1, "R7");
    push(0, 0, 32'd0, "R7 restarted window closed");

    // R7 keyed and unmapped writes do not restart
    step(1'b1, A_UNL, KEY, "R2");
    idle(20, "R7");
    step(1'b1, A_KEY, 32'h5A00_0001, "R7");
    step(1'b1, 8'hE0, 32'hFFFF_FFFF, "R7");
    idle(9, "R7");
    push(0, 0, 32'd1, "R7 open after 31 non-bank cycles");
    idle(1, "R7");
    push(0, 0, 32'd0, "R7 other writes did not restart");

    // R8 / R9 keyed register
    step(1'b1, A_KEY, 32'hA512_3456, "R8");
    exp_keyed("R8 wrong key ignored");
    step(1'b1, A_KEY, 32'h5AAB_CDEF, "R8");
    exp_keyed("R8 correct key while bank locked");
    exp_rd(A_KEY, 32'h00AB_CDEF, "R9");
    step(1'b1, A_KEY, 32'h0000_0001, "R8");
    exp_keyed("R8 relock write ignored");
    exp_rd(A_KEY, 32'h00AB_CDEF, "R9");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule